// File: doc/BRIEF.md
# Viterbi Survivor Memory and Traceback Unit

This block keeps the survivor history of a hard-decision Viterbi decoder and turns it into decoded bits. Every cycle in which `in_valid` is high, an external add-compare-select array delivers one decision vector with one bit per trellis state. The block stores that vector whole in one row of a bank of `ROWS` row registers. A rotating write pointer picks the row, so stored data never moves between rows. Only the row being written has its write enable raised, which is the hook for gating the clock of every other row.

In the cycle after each accepted vector, a combinational walk runs back through all `ROWS` stored vectors. The walk starts at state 0, not at the state with the best metric, and relies on the survivor paths having merged by the time the walk reaches the oldest row. The most significant bit of the state reached at the end is emitted as the decoded bit. No winner path and no path metric are held here.

A two-state controller tracks filling. It starts in `ST_FILL` after reset and stays there while the memory holds fewer than `ROWS` vectors. It takes the transition *fill_done* to `ST_RUN` on the cycle that accepts vector number `ROWS`. It stays in `ST_RUN` until the next reset, which is the transition *reset_to_fill*. In `ST_RUN` every accepted vector produces one output one cycle later.

Top module: `vsm_traceback`

## Requirements
- R1: Bit i of `in_dec` is the decision of state i. While tracing back, the predecessor of state s (s[1] is the newest input bit, s[0] the older one) under decision d is {s[0], d}.
- R2: Each accepted vector is written whole into the row selected by the write pointer. The pointer then advances by one modulo `ROWS`, and rows are never shifted.
- R3: A write enable is raised only for the row being written, and only in a cycle with `in_valid` high. When `in_valid` is low, `in_dec` is ignored and every row and the pointer hold their values.
- R4: The traceback starts at state 0 at the newest stored vector and walks back through `ROWS` vectors. `out_bit` is the MSB of the state reached.
- R5: `out_valid` is high exactly in the cycle after an `in_valid` cycle that found at least `ROWS` vectors already accepted since reset. In every other cycle it is low.
- R6: The walk that `out_bit` reflects includes the vector accepted in the preceding cycle as its newest step.
- R7: Reset returns the controller to `ST_FILL` and the pointer to row 0, and holds `out_valid` low. Row contents are not cleared.
- R8: With error-free input from a rate-1/2, K=3 encoder (generators 7 and 5, start state 0) and a minimum-distance add-compare-select, the output for accepted vector j equals input bit j−`ROWS`.
- R9: The latency is counted in accepted vectors, not in cycles. Idle cycles between vectors do not change the decoded stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A decision vector is present this cycle |
| in_dec | input | 4 | Decision vector, one bit per state (2**(K-1) bits) |
| out_valid | output | 1 | `out_bit` holds a decoded bit |
| out_bit | output | 1 | Decoded bit from the traceback |

## Verification
The bench first sends random data through an encoder and a behavioural add-compare-select model. It checks the decoded stream both against a queue-based traceback and against the delayed input bits. This shows the predecessor rule and the latency are right together. It then sends constant and alternating input bits, and the same random stream with idle gaps carrying random `in_dec`. The gaps separate counting in vectors from counting in cycles and expose any write made on an idle cycle. Finally it drives hand-made vectors, for example only state 0 deciding 1. In that case starting the walk at state 0 gives a different bit than starting at state 3, so the test shows that the fixed start state is used. A reset in the middle of a run confirms that filling starts over.

// File: rtl/vsm_pkg.sv
package vsm_pkg;
    typedef enum logic {
        ST_FILL = 1'b0,
        ST_RUN  = 1'b1
    } fill_state_e;
endpackage

// File: rtl/vsm_wr_ctrl.sv
module vsm_wr_ctrl
    import vsm_pkg::*;
#(
    parameter int ROWS = 32,
    localparam int PW = $clog2(ROWS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic [PW-1:0]   wptr,
    output logic [ROWS-1:0] we,
    output logic            running
);
    localparam logic [PW-1:0] LAST = PW'(ROWS - 1);

    fill_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FILL;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL: if (in_valid && wptr == LAST) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        wptr <= '0;
        else if (in_valid) wptr <= (wptr == LAST) ? '0 : wptr + PW'(1);
    end

    always_comb begin
        we = '0;
        if (in_valid) we[wptr] = 1'b1;
        running = (state_q == ST_RUN);
    end

    p_onehot_we_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we));
    p_no_we_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> (we == '0));
    p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> wptr == (($past(wptr) == LAST) ? '0 : $past(wptr) + PW'(1)));
    p_ptr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(wptr));
    p_run_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |=> (state_q == ST_RUN));
endmodule

// File: rtl/vsm_rows.sv
module vsm_rows #(
    parameter int ROWS = 32,
    parameter int NS   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ROWS-1:0]          we,
    input  logic [NS-1:0]            din,
    output logic [ROWS-1:0][NS-1:0]  rows
);
    for (genvar i = 0; i < ROWS; i++) begin : g_row
        always_ff @(posedge clk) begin
            if (we[i]) rows[i] <= din;
        end

        p_row_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !we[i] |=> $stable(rows[i]));
        p_row_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
            we[i] |=> rows[i] == $past(din));
    end
endmodule

// File: rtl/vsm_walk.sv
module vsm_walk #(
    parameter int ROWS = 32,
    parameter int K    = 3,
    localparam int SW  = K - 1,
    localparam int NS  = 1 << SW,
    localparam int PW  = $clog2(ROWS)
) (
    input  logic [ROWS-1:0][NS-1:0] rows,
    input  logic [PW-1:0]           wptr,
    output logic                    dec_bit
);
    logic [SW-1:0] st;
    logic [PW-1:0] idx;

    always_comb begin
        st  = '0;
        idx = wptr;
        for (int k = 0; k < ROWS; k++) begin
            idx = (idx == '0) ? PW'(ROWS - 1) : idx - PW'(1);
            st  = {st[SW-2:0], rows[idx][st]};
        end
        dec_bit = st[SW-1];
    end
endmodule

// File: rtl/vsm_traceback.sv
module vsm_traceback #(
    parameter int K    = 3,
    parameter int ROWS = 32,
    localparam int NS  = 1 << (K - 1),
    localparam int PW  = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [NS-1:0] in_dec,
    output logic          out_valid,
    output logic          out_bit
);
    logic [PW-1:0]           wptr;
    logic [ROWS-1:0]         we;
    logic                    running;
    logic [ROWS-1:0][NS-1:0] rows;

    vsm_wr_ctrl #(.ROWS(ROWS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .wptr(wptr), .we(we), .running(running)
    );

    vsm_rows #(.ROWS(ROWS), .NS(NS)) u_rows (
        .clk(clk), .rst_n(rst_n), .we(we), .din(in_dec), .rows(rows)
    );

    vsm_walk #(.ROWS(ROWS), .K(K)) u_walk (
        .rows(rows), .wptr(wptr), .dec_bit(out_bit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid && running;
    end

    p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && running) |=> out_valid);
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_fill_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> !out_valid);
endmodule

// File: tb/tb_vsm_traceback.sv
module tb_vsm_traceback;
    localparam int CLK_PERIOD = 10;
    localparam int ROWS = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [3:0] in_dec = '0;
    logic out_valid, out_bit;

    int total = 0, bad = 0;
    logic [3:0] vq[$];
    int bq[$];
    logic exp_v = 1'b0, exp_b = 1'b0;
    int exp_plain = -1;
    int pm[4];
    logic [1:0] es;

    always #(CLK_PERIOD/2) clk = ~clk;

    vsm_traceback dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_dec(in_dec), .out_valid(out_valid), .out_bit(out_bit));

    task automatic fail_line(input string req, input int act, input int exp);
        bad++;
        $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    endtask

    function automatic logic ref_walk();
        logic [1:0] st = 2'b00;
        for (int k = 0; k < ROWS; k++) begin
            logic [3:0] v = vq[vq.size() - 1 - k];
            st = {st[0], v[st]};
        end
        return st[1];
    endfunction

    task automatic check_outputs();
        total++;
        if (out_valid !== exp_v) fail_line("R5 out_valid", out_valid, exp_v);
        if (exp_v) begin
            total++;
            if (out_bit !== exp_b) fail_line("R4/R6 traceback bit", out_bit, exp_b);
            if (exp_plain >= 0) begin
                total++;
                if (out_bit !== exp_plain[0]) fail_line("R8 decoded bit", out_bit, exp_plain);
            end
        end
    endtask

    task automatic tick(input logic v, input logic [3:0] d, input int b);
        @(negedge clk);
        check_outputs();
        in_valid = v;
        in_dec = d;
        exp_v = 1'b0;
        exp_plain = -1;
        if (v) begin
            vq.push_back(d);
            bq.push_back(b);
            if (vq.size() > ROWS) begin
                exp_v = 1'b1;
                exp_b = ref_walk();
                exp_plain = bq[bq.size() - 1 - ROWS];
            end
        end
    endtask

    task automatic acs_step(input logic b, output logic [3:0] dv);
        logic c0, c1;
        int npm[4];
        c0 = b ^ es[1] ^ es[0];
        c1 = b ^ es[0];
        es = {b, es[1]};
        for (int s = 0; s < 4; s++) begin
            int best = 1 << 30;
            logic bd = 1'b0;
            for (int d = 0; d < 2; d++) begin
                logic [1:0] p = {s[0], d[0]};
                logic e0 = s[1] ^ p[1] ^ p[0];
                logic e1 = s[1] ^ p[0];
                int m = pm[p] + int'(e0 != c0) + int'(e1 != c1);
                if (m < best) begin best = m; bd = d[0]; end
            end
            npm[s] = best;
            dv[s] = bd;
        end
        pm = npm;
    endtask

    task automatic send_bit(input logic b);
        logic [3:0] dv;
        acs_step(b, dv);
        tick(1'b1, dv, int'(b));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        total++;
        if (out_valid !== 1'b0) fail_line("R7 reset out_valid", out_valid, 0);
        vq.delete();
        bq.delete();
        exp_v = 1'b0;
        exp_plain = -1;
        pm = '{0, 1000, 1000, 1000};
        es = 2'b00;
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        do_reset();
        // R8, R5, R4: continuous random encoded stream
        for (int i = 0; i < 200; i++) send_bit(1'($urandom));
        // R9, R3: random gaps carrying random decisions
        for (int i = 0; i < 300; i++) begin
            if ($urandom_range(1, 0) == 1) send_bit(1'($urandom));
            else tick(1'b0, 4'($urandom), -1);
        end
        // R7, R5: reset mid-run, refill with constant zeros then ones
        do_reset();
        for (int i = 0; i < 40; i++) send_bit(1'b0);
        for (int i = 0; i < 40; i++) send_bit(1'b1);
        for (int i = 0; i < 60; i++) send_bit(1'(i & 1));
        // R4, R1: only state 0 decides 1, start state changes the result
        do_reset();
        for (int i = 0; i < 45; i++) tick(1'b1, 4'b0001, -1);
        // R1, R2: arbitrary decision vectors with gaps
        for (int i = 0; i < 150; i++) begin
            if ($urandom_range(3, 0) != 0) tick(1'b1, 4'($urandom), -1);
            else tick(1'b0, 4'($urandom), -1);
        end
        tick(1'b0, 4'b0000, -1);
        tick(1'b0, 4'b0000, -1);
        finish_run();
    end
endmodule